// File: doc/BRIEF.md
# I2C-Mode Byte Shifter with Acknowledge Events

This block moves one byte per frame over an open-drain SDA/SCL pair whose clock comes from outside. A frame is nine SCL clocks: eight data bits, MSB first, then one acknowledge bit. Software loads a byte with a one-cycle load strobe. The unit then pulls SDA low for each zero bit and releases it for each one bit. It samples the resolved line on every SCL rising edge, so a byte written as all ones receives whatever the other bus party drives.

Both bus inputs first pass through a glitch filter and are then used on their filtered edges. Two words in this brief name the edges of the acknowledge slot. The *slot-opening edge* is the SCL falling edge that ends the eighth clock. The *ack rising edge* is the rising edge of the ninth clock. An event-mode bit selects between two sets of strobes: acknowledge/no-acknowledge, or byte received/byte sent. A delayed-phase bit, combined with event mode 1, splits the receive-buffer update into two loads with different bit layouts. Before the first frame after enabling, SDA follows a default level that can only be written while the unit is disabled.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, sda_oe is 0 (default level is high, so the line is released), rx_buf is 0, and no event strobe is high.
- R2: dflt_val is captured on dflt_wr only while enable is 0; a write while enabled has no effect. While disabled, and after enabling until the first tx_load, sda_oe equals the inverse of the stored default level.
- R3: SDA is open-drain. During data bits sda_oe is 1 exactly when the current bit is 0, bits go out MSB first and advance on each filtered SCL falling edge. sda_oe is 0 through the acknowledge slot and after the frame ends.
- R4: A frame has nine SCL clocks. The filtered SDA level at the rising edges of clocks 1 to 8 forms the received byte, first bit in the MSB. The falling edge of the ninth clock ends the frame.
- R5: With evt_mode = 0, the ack rising edge raises ev_ack if SDA is low and ev_nack if SDA is high. ev_rx and ev_tx stay low.
- R6: With evt_mode = 1, ev_rx fires at the slot-opening edge and ev_tx at the falling edge of the ninth clock. ev_ack and ev_nack stay low.
- R7: Unless evt_mode = 1 and ck_delay = 1, the slot-opening edge loads rx_buf[7:0] with the received byte and clears rx_buf[8].
- R8: With evt_mode = 1 and ck_delay = 1, the slot-opening edge loads received bits 1 to 7 into rx_buf[6:0] and bit 8 into rx_buf[8]. rx_buf[7] is kept, so {rx_buf[6:0], rx_buf[8]} reads as the byte in order.
- R9: In that same configuration, the ack rising edge rewrites rx_buf[7:0] with the received byte. rx_buf[8] is kept.
- R10: A level change on SCL or SDA takes effect only after it holds for FILT_CYC consecutive clock cycles. A shorter SCL pulse neither advances nor disturbs the frame.
- R11: In any cycle where evt_mode or ck_delay differs from its value one cycle earlier, no event strobe is raised in the following cycle.
- R12: Each event is a single-cycle strobe, raised once per qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; 0 aborts any frame |
| evt_mode | input | 1 | 0: ack/nack strobes; 1: byte receive/transmit strobes |
| ck_delay | input | 1 | Delayed-phase option (two-step buffer load in event mode 1) |
| dflt_wr | input | 1 | Write strobe for the default SDA level (disabled only) |
| dflt_val | input | 1 | Default SDA level to store |
| tx_data | input | 8 | Byte to shift out |
| tx_load | input | 1 | Load tx_data and arm a frame |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_buf | output | 9 | Receive buffer |
| ev_ack | output | 1 | Acknowledge seen strobe |
| ev_nack | output | 1 | No-acknowledge seen strobe |
| ev_rx | output | 1 | Byte received strobe |
| ev_tx | output | 1 | Byte sent strobe |

## Verification
The hardest case to reach is a configuration change landing on the exact cycle an ack strobe would be computed. That cycle sits after two synchronizer stages, the glitch filter and the edge detector, so a single timed write is fragile. The bench instead toggles the phase bit every cycle across the whole ninth clock high phase of one frame, so every candidate cycle sees a change. It then checks that no ack or nack strobe appeared while the buffer still received the byte. Catching the transient first-load layout needs a similar approach: the bench samples the buffer in the middle of the acknowledge slot's low phase, between the two loads.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  parameter int unsigned I2CB_DW = 8;
  parameter int unsigned I2CB_BW = I2CB_DW + 1;

  // Single-step layout: byte in low bits, top bit cleared.
  function automatic logic [I2CB_BW-1:0] lay_single(input logic [I2CB_DW-1:0] b);
    return {1'b0, b};
  endfunction

  // Early layout: bits 1..7 one place down, last bit parked on top, bit 7 kept.
  function automatic logic [I2CB_BW-1:0] lay_early(input logic [I2CB_BW-1:0] cur,
                                                   input logic [I2CB_DW-1:0] b);
    return {b[0], cur[I2CB_DW-1], b[I2CB_DW-1:1]};
  endfunction

  // Late layout: byte in low bits, top bit kept.
  function automatic logic [I2CB_BW-1:0] lay_late(input logic [I2CB_BW-1:0] cur,
                                                  input logic [I2CB_DW-1:0] b);
    return {cur[I2CB_DW], b};
  endfunction
endpackage

// File: rtl/i2cb_glitch_filter.sv
module i2cb_glitch_filter #(
  parameter int unsigned FILT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      filt_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == filt_o) begin
        run_q <= '0;
      end else if (run_q == LIMIT) begin
        filt_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // A filtered change needs a full run of differing samples.
  assert_filt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_o != $past(filt_o)) |-> ($past(run_q) == LIMIT));
endmodule

// File: rtl/i2cb_shift_core.sv
module i2cb_shift_core
  import i2cb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tx_load,
  input  logic [I2CB_DW-1:0] tx_data,
  input  logic               scl_f,
  input  logic               sda_f,
  output logic               started,
  output logic               drive_low,
  output logic               slot_open,
  output logic               ack_rise,
  output logic               frame_end,
  output logic               ack_lvl,
  output logic [I2CB_DW-1:0] rx_byte
);
  localparam int unsigned CW = $clog2(I2CB_DW + 1);
  localparam logic [CW-1:0] ACK_IDX   = CW'(I2CB_DW);
  localparam logic [CW-1:0] LAST_DATA = CW'(I2CB_DW - 1);

  logic               scl_q, busy;
  logic [CW-1:0]      cnt;
  logic [I2CB_DW-1:0] tx_sh, rx_sh;
  logic               rise, fall, live;

  assign rise      = scl_f & ~scl_q;
  assign fall      = ~scl_f & scl_q;
  assign live      = enable & busy & ~tx_load;
  assign slot_open = live & fall & (cnt == LAST_DATA);
  assign ack_rise  = live & rise & (cnt == ACK_IDX);
  assign frame_end = live & fall & (cnt == ACK_IDX);
  assign ack_lvl   = sda_f;
  assign rx_byte   = rx_sh;
  assign drive_low = busy & (cnt != ACK_IDX) & ~tx_sh[I2CB_DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      busy    <= 1'b0;
      started <= 1'b0;
      cnt     <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
    end else begin
      scl_q <= scl_f;
      if (!enable) begin
        busy    <= 1'b0;
        started <= 1'b0;
        cnt     <= '0;
      end else if (tx_load) begin
        tx_sh   <= tx_data;
        cnt     <= '0;
        busy    <= 1'b1;
        started <= 1'b1;
      end else if (busy) begin
        if (rise && cnt != ACK_IDX) rx_sh <= {rx_sh[I2CB_DW-2:0], sda_f};
        if (fall) begin
          if (cnt == ACK_IDX) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt   <= cnt + 1'b1;
            tx_sh <= {tx_sh[I2CB_DW-2:0], 1'b1};
          end
        end
      end
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ACK_IDX);
  assert_frame_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);
endmodule

// File: rtl/i2cb_rx_buffer.sv
module i2cb_rx_buffer
  import i2cb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               two_step,
  input  logic               slot_open,
  input  logic               ack_rise,
  input  logic [I2CB_DW-1:0] rx_byte,
  output logic [I2CB_BW-1:0] rx_buf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
    end else if (slot_open) begin
      rx_buf <= two_step ? lay_early(rx_buf, rx_byte) : lay_single(rx_byte);
    end else if (ack_rise && two_step) begin
      rx_buf <= lay_late(rx_buf, rx_byte);
    end
  end

  assert_single_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && !two_step) |=> (rx_buf == {1'b0, $past(rx_byte)}));
  assert_early_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_open && two_step) |=>
      (rx_buf[I2CB_DW-2:0] == $past(rx_byte[I2CB_DW-1:1])) &&
      (rx_buf[I2CB_DW] == $past(rx_byte[0])));
  assert_late_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && two_step) |=>
      (rx_buf[I2CB_DW-1:0] == $past(rx_byte)) && $stable(rx_buf[I2CB_DW]));
endmodule

// File: rtl/i2cb_event_unit.sv
module i2cb_event_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_mode,
  input  logic ck_delay,
  input  logic slot_open,
  input  logic ack_rise,
  input  logic frame_end,
  input  logic ack_lvl,
  output logic ev_ack,
  output logic ev_nack,
  output logic ev_rx,
  output logic ev_tx
);
  logic [1:0] cfg_q;
  logic       cfg_chg;

  assign cfg_chg = ({evt_mode, ck_delay} != cfg_q);

  always_ff @(posedge clk) cfg_q <= {evt_mode, ck_delay};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_ack  <= 1'b0;
      ev_nack <= 1'b0;
      ev_rx   <= 1'b0;
      ev_tx   <= 1'b0;
    end else begin
      ev_ack  <= ack_rise  & ~evt_mode & ~ack_lvl & ~cfg_chg;
      ev_nack <= ack_rise  & ~evt_mode &  ack_lvl & ~cfg_chg;
      ev_rx   <= slot_open &  evt_mode & ~cfg_chg;
      ev_tx   <= frame_end &  evt_mode & ~cfg_chg;
    end
  end

  assert_ack_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_nack) |-> !$past(evt_mode));
  assert_byte_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx || ev_tx) |-> $past(evt_mode));
  assert_cfg_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({evt_mode, ck_delay} != $past({evt_mode, ck_delay})) |=>
      !(ev_ack || ev_nack || ev_rx || ev_tx));
  assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack || ev_nack || ev_rx || ev_tx) |=> !(ev_ack || ev_nack || ev_rx || ev_tx));
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2cb_pkg::*;
#(
  parameter int unsigned FILT_CYC = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               evt_mode,
  input  logic               ck_delay,
  input  logic               dflt_wr,
  input  logic               dflt_val,
  input  logic [I2CB_DW-1:0] tx_data,
  input  logic               tx_load,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [I2CB_BW-1:0] rx_buf,
  output logic               ev_ack,
  output logic               ev_nack,
  output logic               ev_rx,
  output logic               ev_tx
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] line_raw, line_filt;
  logic              dflt_q, started, drive_low;
  logic              slot_open, ack_rise, frame_end, ack_lvl;
  logic [I2CB_DW-1:0] rx_byte;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cb_glitch_filter #(.FILT_CYC(FILT_CYC)) filt_i (
      .clk(clk), .rst_n(rst_n), .raw_i(line_raw[g]), .filt_o(line_filt[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dflt_q <= 1'b1;
    else if (!enable && dflt_wr) dflt_q <= dflt_val;
  end

  i2cb_shift_core core_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_load(tx_load), .tx_data(tx_data),
    .scl_f(line_filt[1]), .sda_f(line_filt[0]), .started(started), .drive_low(drive_low),
    .slot_open(slot_open), .ack_rise(ack_rise), .frame_end(frame_end),
    .ack_lvl(ack_lvl), .rx_byte(rx_byte));

  i2cb_rx_buffer buf_i (
    .clk(clk), .rst_n(rst_n), .two_step(evt_mode & ck_delay), .slot_open(slot_open),
    .ack_rise(ack_rise), .rx_byte(rx_byte), .rx_buf(rx_buf));

  i2cb_event_unit evt_i (
    .clk(clk), .rst_n(rst_n), .evt_mode(evt_mode), .ck_delay(ck_delay),
    .slot_open(slot_open), .ack_rise(ack_rise), .frame_end(frame_end), .ack_lvl(ack_lvl),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_rx(ev_rx), .ev_tx(ev_tx));

  assign sda_oe = started ? drive_low : ~dflt_q;

  assert_dflt_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (dflt_q == $past(dflt_q)));
  assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |-> !sda_oe);
endmodule

// File: tb/i2c_byte_shifter_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_shifter_tb_top;
  localparam int FILT = 6;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, evt_mode = 0, ck_base = 0, tog = 0, tog_en = 0;
  logic dflt_wr = 0, dflt_val = 0, tx_load = 0;
  logic [7:0] tx_data = 8'hFF;
  logic scl = 1'b1, mst_low = 1'b0;
  logic ck_delay, line, sda_oe;
  logic [8:0] rx_buf;
  logic ev_ack, ev_nack, ev_rx, ev_tx;
  int n_ack = 0, n_nack = 0, n_rx = 0, n_tx = 0;
  int checks = 0, errors = 0;
  logic [8:0] exp_buf = '0;

  always #2.5 clk = ~clk;

  assign ck_delay = ck_base ^ tog;
  assign line = ~(sda_oe | mst_low);

  i2c_byte_shifter #(.FILT_CYC(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .evt_mode(evt_mode), .ck_delay(ck_delay),
    .dflt_wr(dflt_wr), .dflt_val(dflt_val), .tx_data(tx_data), .tx_load(tx_load),
    .scl_i(scl), .sda_i(line), .sda_oe(sda_oe), .rx_buf(rx_buf),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .ev_rx(ev_rx), .ev_tx(ev_tx));

  always @(negedge clk) begin
    if (ev_ack) n_ack++;
    if (ev_nack) n_nack++;
    if (ev_rx) n_rx++;
    if (ev_tx) n_tx++;
  end

  always @(posedge clk) tog <= tog_en ? ~tog : 1'b0;

  function automatic logic [8:0] f_single(input logic [7:0] b);
    return {1'b0, b};
  endfunction
  function automatic logic [7:0] f_inorder(input logic [8:0] bv);
    logic [7:0] r;
    r[0] = bv[8];
    for (int k = 1; k < 8; k++) r[k] = bv[k-1];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] tx, input logic [7:0] mb, input bit ackb,
                       input bit glitch, input bit togl);
    logic [7:0] rx, obs;
    int a0, b0, c0, d0;
    bit two;
    rx = tx & mb;
    obs = '0;
    two = evt_mode & ck_base;
    a0 = n_ack; b0 = n_nack; c0 = n_rx; d0 = n_tx;
    @(negedge clk) scl = 1'b0;
    cyc(HALF / 2);
    tx_data = tx; tx_load = 1'b1;
    cyc(1);
    tx_load = 1'b0;
    cyc(HALF / 2);
    for (int i = 0; i < 9; i++) begin
      mst_low = (i < 8) ? ~mb[7-i] : ~ackb;
      if (glitch && i == 3) begin
        cyc(10); scl = 1'b1; cyc(3); scl = 1'b0; cyc(HALF / 2 - 13);
      end else begin
        cyc(HALF / 2);
      end
      if (i == 8) begin
        if (two) begin
          exp_buf = {rx[0], exp_buf[7], rx[7:1]};
          chk(rx_buf == exp_buf, "R8", "early buffer layout", rx_buf, exp_buf);
          chk(f_inorder(rx_buf) == rx, "R8", "early buffer read in order",
              f_inorder(rx_buf), rx);
        end else begin
          exp_buf = f_single(rx);
          chk(rx_buf == exp_buf, "R7", "single buffer load", rx_buf, exp_buf);
        end
        if (togl) tog_en = 1'b1;
      end
      cyc(HALF / 2);
      scl = 1'b1;
      cyc(HALF / 2);
      if (i < 8) obs[7-i] = line;
      else chk(sda_oe == 1'b0, "R3", "released in ack slot", sda_oe, 0);
      cyc(HALF / 2);
      tog_en = 1'b0;
      scl = 1'b0;
    end
    mst_low = 1'b0;
    cyc(HALF);
    scl = 1'b1;
    cyc(HALF);
    chk(obs == rx, (mb == 8'hFF) ? "R3" : "R4", "line bits", obs, rx);
    chk(sda_oe == 1'b0, "R3", "released after frame", sda_oe, 0);
    if (two) exp_buf = {exp_buf[8], rx};
    chk(rx_buf == exp_buf, two ? "R9" : "R7", "final buffer", rx_buf, exp_buf);
    if (togl) begin
      chk((n_ack - a0) + (n_nack - b0) == 0, "R11", "strobes under cfg change",
          (n_ack - a0) + (n_nack - b0), 0);
    end else if (!evt_mode) begin
      chk((n_ack - a0) == int'(!ackb) && (n_nack - b0) == int'(ackb) &&
          (n_rx - c0) == 0 && (n_tx - d0) == 0, "R5 R12", "ack strobes",
          {n_ack - a0, n_nack - b0, n_rx - c0, n_tx - d0},
          {int'(!ackb), int'(ackb), 0, 0});
    end else begin
      chk((n_rx - c0) == 1 && (n_tx - d0) == 1 && (n_ack - a0) == 0 &&
          (n_nack - b0) == 0, "R6 R12", "byte strobes",
          {n_ack - a0, n_nack - b0, n_rx - c0, n_tx - d0}, {0, 0, 1, 1});
    end
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    chk(sda_oe == 1'b0, "R1", "reset sda_oe", sda_oe, 0);
    chk(rx_buf == 9'd0, "R1", "reset rx_buf", rx_buf, 0);
    chk({ev_ack, ev_nack, ev_rx, ev_tx} == 4'd0, "R1", "reset strobes",
        {ev_ack, ev_nack, ev_rx, ev_tx}, 0);
    dflt_val = 1'b0; dflt_wr = 1'b1; cyc(1); dflt_wr = 1'b0; cyc(1);
    chk(sda_oe == 1'b1, "R2", "default low while disabled", sda_oe, 1);
    enable = 1'b1; cyc(2);
    dflt_val = 1'b1; dflt_wr = 1'b1; cyc(1); dflt_wr = 1'b0; cyc(1);
    chk(sda_oe == 1'b1, "R2", "write ignored while enabled", sda_oe, 1);
    // directed frames
    evt_mode = 0; ck_base = 0;
    frame(8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0);
    frame(8'hFF, 8'h3C, 1'b1, 1'b0, 1'b0);
    evt_mode = 1; ck_base = 0; cyc(4);
    frame(8'h81, 8'hFF, 1'b0, 1'b0, 1'b0);
    evt_mode = 1; ck_base = 1; cyc(4);
    frame(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
    frame(8'hFF, 8'h6B, 1'b0, 1'b0, 1'b0);
    evt_mode = 0; ck_base = 0; cyc(4);
    frame(8'hC3, 8'hFF, 1'b0, 1'b1, 1'b0);   // R10 short SCL pulse
    frame(8'h5A, 8'hFF, 1'b0, 1'b0, 1'b1);   // R11 config churn
    enable = 1'b0; cyc(2);
    chk(sda_oe == 1'b1, "R2", "default again after disable", sda_oe, 1);
    dflt_val = 1'b1; dflt_wr = 1'b1; cyc(1); dflt_wr = 1'b0; cyc(1);
    chk(sda_oe == 1'b0, "R2", "default high written while disabled", sda_oe, 0);
    enable = 1'b1; cyc(2);
    // random frames
    void'($urandom(32'h1c2b));
    for (int n = 0; n < 28; n++) begin
      logic [7:0] t, m;
      t = 8'($urandom);
      m = ($urandom % 2) ? 8'hFF : 8'($urandom);
      evt_mode = 1'($urandom); ck_base = 1'($urandom); cyc(4);
      frame(t, m, 1'($urandom), 1'b0, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule